// File: doc/BRIEF.md
# Power-Good Delay Sequencer

This block produces the power-good indication of a multi-rail supply supervisor. It watches three digital "good" flags: an external power-good input and two rail flags that say the 3.3 V and 5 V outputs are above their under-voltage limits. It also watches two internal controls: the already-filtered supply-off request and a flag that says a protection fault has been latched. The indication rises only after every condition has held without a break for a long qualification interval, about 300 ms in the target system. It falls on the first clock edge that sees any condition fail.

The three flags can arrive from outside the clock domain, so each one passes through a synchronizer. The external power-good flag is also deglitched, which rejects short excursions in either direction. All intervals are counted in clock cycles. The parameters give cycle counts, so the same block fits any clock frequency. The defaults assume a 50 MHz clock: 15,000,000 cycles for the qualification delay and 7,500 cycles for the 150 µs deglitch.

Top module: `pwr_good_seq`

## Requirements
- R1: While `rst` is high, and after it is released, `pwr_good_out` is 0. It stays 0 until a complete qualification period has elapsed.
- R2: "All good" means all of the following hold: the filtered external flag is 1, both synchronized rail flags are 1, `supply_off_req` is 0 and `fault_latched` is 0. `pwr_good_out` rises on the QUAL_CYCLES-th consecutive clock edge at which all good holds.
- R3: Any edge at which all good does not hold restarts qualification from zero. After such an edge, QUAL_CYCLES new consecutive good edges are required.
- R4: When `rail3v3_ok_in` or `rail5v_ok_in` falls to 0, `pwr_good_out` goes to 0 at the third clock edge after the change. This is SYNC_STAGES synchronizer edges plus one output register edge, with no qualification delay.
- R5: The external flag is deglitched. A new level of `ext_good_in` is accepted only after it has been held for DEGLITCH_CYCLES clock cycles. A shorter excursion has no effect on `pwr_good_out`.
- R6: `fault_latched` at 1 drives `pwr_good_out` to 0 at the next clock edge.
- R7: `supply_off_req` at 1 (meaning off) drives `pwr_good_out` to 0 at the next clock edge, whatever the other inputs are.
- R8: The qualification counter saturates at QUAL_CYCLES. `pwr_good_out` therefore stays 1 without glitches for as long as all good holds.
- R9: When `ext_good_in` falls to 0 and stays low, `pwr_good_out` goes to 0 at clock edge SYNC_STAGES + DEGLITCH_CYCLES + 1 after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_good_in | input | 1 | External power-good flag, 1 = good, asynchronous |
| rail3v3_ok_in | input | 1 | 3.3 V rail above under-voltage limit, asynchronous |
| rail5v_ok_in | input | 1 | 5 V rail above under-voltage limit, asynchronous |
| supply_off_req | input | 1 | Filtered on/off state, 1 = supply off |
| fault_latched | input | 1 | 1 = a protection fault is latched |
| pwr_good_out | output | 1 | Registered power-good indication |

## Verification
Suppose the qualification counter holds a wrong value, for example because it missed a restart or wrapped around instead of saturating. That error shows at the port as a rise of `pwr_good_out` that comes too early, comes too late or glitches while the inputs are steady. It becomes visible within one qualification period of the fault. Suppose instead the deglitch filter is in a wrong state. That error shows as a loss of power-good after a short dip on the external flag, or as a drop latency that differs from SYNC_STAGES + DEGLITCH_CYCLES + 1 edges, so it appears within a few deglitch intervals. Both are measured against a cycle-accurate model in the bench, under random stimulus and at the exact boundary lengths.

// File: rtl/pg_pkg.sv
package pg_pkg;
  // positions of the monitored flags on the synchronized bus
  localparam int unsigned MON_COUNT = 3;
  localparam int unsigned IDX_RAIL5 = 0;
  localparam int unsigned IDX_RAIL3 = 1;
  localparam int unsigned IDX_EXT   = 2;

  typedef logic [MON_COUNT-1:0] mon_bus_t;

  // width of a counter that must reach the value lim
  function automatic int unsigned cnt_width(input longint unsigned lim);
    int unsigned w;
    w = 1;
    while ((longint'(1) << w) <= lim) w++;
    return w;
  endfunction
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] stage [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
          stage[0] <= d;
          for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
      end
      assign q = stage[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pg_deglitch.sv
module pg_deglitch #(
  parameter int unsigned HOLD_CYCLES = 7500
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = pg_pkg::cnt_width(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;

  // a new level is taken once it has differed for HOLD_CYCLES edges
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (din != lvl_q) begin
      if (run_q == LAST) begin
        lvl_q <= din;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign dout = lvl_q;
endmodule

// File: rtl/pg_qual_timer.sv
module pg_qual_timer #(
  parameter int unsigned QUAL_CYCLES = 15_000_000,
  parameter int unsigned CW          = pg_pkg::cnt_width(QUAL_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cond_ok,
  output logic [CW-1:0] count,
  output logic          pg
);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);
  localparam logic [CW-1:0] ARM   = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          pg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pg_q  <= 1'b0;
    end else if (!cond_ok) begin
      cnt_q <= '0;
      pg_q  <= 1'b0;
    end else begin
      if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      pg_q <= (cnt_q >= ARM);
    end
  end

  assign count = cnt_q;
  assign pg    = pg_q;
endmodule

// File: rtl/pwr_good_seq.sv
module pwr_good_seq #(
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned DEGLITCH_CYCLES = 7_500,
  parameter int unsigned QUAL_CYCLES     = 15_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_good_in,
  input  logic rail3v3_ok_in,
  input  logic rail5v_ok_in,
  input  logic supply_off_req,
  input  logic fault_latched,
  output logic pwr_good_out
);
  import pg_pkg::*;

  localparam int unsigned QCW = cnt_width(QUAL_CYCLES);

  mon_bus_t       raw_bus;
  mon_bus_t       sync_bus;
  logic           ext_flt;
  logic           all_good;
  logic [QCW-1:0] qual_cnt;

  always_comb begin
    raw_bus            = '0;
    raw_bus[IDX_EXT]   = ext_good_in;
    raw_bus[IDX_RAIL3] = rail3v3_ok_in;
    raw_bus[IDX_RAIL5] = rail5v_ok_in;
  end

  pg_sync #(.WIDTH(MON_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(sync_bus)
  );

  pg_deglitch #(.HOLD_CYCLES(DEGLITCH_CYCLES)) u_ext_flt (
    .clk(clk), .rst(rst), .din(sync_bus[IDX_EXT]), .dout(ext_flt)
  );

  assign all_good = ext_flt & sync_bus[IDX_RAIL3] & sync_bus[IDX_RAIL5]
                  & ~supply_off_req & ~fault_latched;

  pg_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES), .CW(QCW)) u_timer (
    .clk(clk), .rst(rst), .cond_ok(all_good), .count(qual_cnt), .pg(pwr_good_out)
  );
endmodule

// File: rtl/pg_seq_checker.sv
module pg_seq_checker #(
  parameter int unsigned QUAL_CYCLES = 15_000_000,
  parameter int unsigned QCW         = 25
) (
  input logic           clk,
  input logic           rst,
  input logic           supply_off_req,
  input logic           fault_latched,
  input logic           all_good,
  input logic [QCW-1:0] qual_cnt,
  input logic           pwr_good_out
);
  localparam logic [QCW-1:0] LIMIT = QCW'(QUAL_CYCLES);

  // independent run length of the good condition
  logic [QCW-1:0] good_run;
  always_ff @(posedge clk) begin
    if (rst) good_run <= '0;
    else if (!all_good) good_run <= '0;
    else if (good_run != LIMIT) good_run <= good_run + 1'b1;
  end

  p_reset_low_r1: assert property (@(posedge clk) rst |=> !pwr_good_out);
  p_rise_after_qual_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_good_out) |-> (good_run >= LIMIT));
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    !all_good |=> (qual_cnt == '0));
  p_drop_at_once_r4: assert property (@(posedge clk) disable iff (rst)
    !all_good |=> !pwr_good_out);
  p_fault_low_r6: assert property (@(posedge clk) disable iff (rst)
    fault_latched |=> !pwr_good_out);
  p_off_low_r7: assert property (@(posedge clk) disable iff (rst)
    supply_off_req |=> !pwr_good_out);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    qual_cnt <= LIMIT);
endmodule

bind pwr_good_seq pg_seq_checker #(.QUAL_CYCLES(QUAL_CYCLES), .QCW(QCW)) u_chk (
  .clk(clk), .rst(rst), .supply_off_req(supply_off_req), .fault_latched(fault_latched),
  .all_good(all_good), .qual_cnt(qual_cnt), .pwr_good_out(pwr_good_out)
);

// File: tb/test_pwr_good_seq.sv
module test_pwr_good_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SS = 2;
  localparam int DC = 8;
  localparam int QC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext = 1'b0, r33 = 1'b0, r5 = 1'b0, off = 1'b1, flt = 1'b0;
  logic pg;
  int checks = 0, errors = 0, cyc = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_good_seq #(.SYNC_STAGES(SS), .DEGLITCH_CYCLES(DC), .QUAL_CYCLES(QC)) i_pwr_good_seq (
    .clk(clk), .rst(rst), .ext_good_in(ext), .rail3v3_ok_in(r33), .rail5v_ok_in(r5),
    .supply_off_req(off), .fault_latched(flt), .pwr_good_out(pg)
  );

  // reference model written from the requirements
  logic [2:0] m1, m2;
  logic m_ext;
  int   m_hold, m_run;
  logic m_pg;

  function automatic bit cond_good(input logic e, input logic [2:0] s,
                                   input logic o, input logic f);
    return e && s[1] && s[0] && !o && !f;
  endfunction

  function automatic int sat_inc(input int v);
    return (v + 1 > QC) ? QC : v + 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m1 <= '0; m2 <= '0; m_ext <= 1'b0; m_hold <= 0; m_run <= 0; m_pg <= 1'b0;
    end else begin
      m1 <= {ext, r33, r5};
      m2 <= m1;
      if (m2[2] != m_ext) begin
        if (m_hold + 1 >= DC) begin m_ext <= m2[2]; m_hold <= 0; end
        else m_hold <= m_hold + 1;
      end else m_hold <= 0;
      if (cond_good(m_ext, m2, off, flt)) begin
        m_run <= sat_inc(m_run);
        m_pg  <= (m_run + 1 >= QC);
      end else begin
        m_run <= 0;
        m_pg  <= 1'b0;
      end
    end
  end

  task automatic chk(input logic exp, input string req);
    checks++;
    if (pg !== exp) begin
      errors++;
      $display("FAIL %s: pwr_good_out=%b expected=%b at cycle %0d", req, pg, exp, cyc);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150_000) begin
      checks++; errors++;
      $display("FAIL watchdog: cycles=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    int bad;
    void'($urandom(32'd4711));
    edges(3);
    chk(1'b0, "R1 in reset");
    rst = 1'b0;
    ext = 1'b1; r33 = 1'b1; r5 = 1'b1;
    edges(20);
    chk(1'b0, "R7 off holds low");
    chk(m_pg, "R1 model");

    // R2: exact qualification length
    off = 1'b0;
    edges(QC - 1); chk(1'b0, "R2 one edge early");
    edges(1);      chk(1'b1, "R2 rise edge");

    // R8: steady while good, longer than counter wrap
    bad = 0;
    for (int i = 0; i < 200; i++) begin edges(1); if (pg !== 1'b1) bad++; end
    checks++;
    if (bad != 0) begin errors++; $display("FAIL R8: low cycles=%0d expected=0", bad); end

    // R6 fault then requalify
    flt = 1'b1; edges(1); chk(1'b0, "R6 fault");
    flt = 1'b0;
    edges(QC - 1); chk(1'b0, "R6 requal early");
    edges(1);      chk(1'b1, "R6 requal");

    // R4 rail drop latency
    r33 = 1'b0;
    edges(SS); chk(1'b1, "R4 before sync");
    edges(1);  chk(1'b0, "R4 3v3 drop");
    r33 = 1'b1;
    edges(SS + QC - 1); chk(1'b0, "R4 requal early");
    edges(1);           chk(1'b1, "R4 requal");
    r5 = 1'b0;
    edges(SS + 1); chk(1'b0, "R4 5v drop");
    r5 = 1'b1;
    edges(SS + QC + 2);

    // R3 restart during qualification
    off = 1'b1; edges(1);
    off = 1'b0; edges(20);
    off = 1'b1; edges(1);
    off = 1'b0;
    edges(QC - 1); chk(1'b0, "R3 restart early");
    edges(1);      chk(1'b1, "R3 restart rise");

    // R5 short dip on external flag is ignored
    ext = 1'b0; edges(DC - 1); ext = 1'b1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin edges(1); if (pg !== 1'b1) bad++; end
    checks++;
    if (bad != 0) begin errors++; $display("FAIL R5: low cycles=%0d expected=0", bad); end

    // R9 held drop latency
    ext = 1'b0;
    edges(SS + DC); chk(1'b1, "R9 before filter");
    edges(1);       chk(1'b0, "R9 drop");
    // R5 accepted rise timing
    ext = 1'b1;
    edges(SS + DC + QC - 1); chk(1'b0, "R5 rise early");
    edges(1);                chk(1'b1, "R5 rise");

    // R7 off while high
    off = 1'b1; edges(1); chk(1'b0, "R7 off while high");
    off = 1'b0; edges(QC + 1);

    // R1 reset while high
    rst = 1'b1; edges(1); chk(1'b0, "R1 reset while high");
    rst = 1'b0;
    edges(QC + SS + DC + 5); chk(m_pg, "R1 after reset model");

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 6) begin
        case ($urandom_range(0, 4))
          0: ext = ~ext;
          1: r33 = ($urandom_range(0, 3) != 0);
          2: r5  = ($urandom_range(0, 3) != 0);
          3: off = ($urandom_range(0, 5) == 0);
          default: flt = ($urandom_range(0, 7) == 0);
        endcase
      end
      if (i % 500 == 499) begin ext = 1'b1; r33 = 1'b1; r5 = 1'b1; off = 1'b0; flt = 1'b0; end
      edges(1);
      chk(m_pg, "R2 random model");
    end
    finish_run();
  end
endmodule